// File: doc/BRIEF.md
# E1 Sa-Bit Change and Sa6 Codeword Monitor

This block sits behind an E1 receive framer. For every received non-align frame it takes the five spare bits Sa4 to Sa8, plus a marker that flags the first non-align frame of a submultiframe. It has two jobs. The first is to report changes of state on the spare bits that the host has chosen to watch. The second is to pull the four Sa6 bits of each submultiframe into a 4-bit codeword and filter them. A codeword is accepted only after it has been received unchanged over three submultiframes in a row. The block does not interpret what a codeword means.

The host reaches the block through a small register port. Writes take effect on the next clock edge, and reads are combinational. The host can choose which Sa positions are watched and which events can interrupt. It can read the live spare bits and the accepted codeword, and it acknowledges events by writing 1 to latched status bits. A single level interrupt line goes high when a latched status bit is set and its mask bit allows it.

Top module: `e1_sa_monitor`

## Requirements
- R1: Bits 4:0 of the enable register (address 0) select Sa4..Sa8 (bit 0 = Sa4, bit 2 = Sa6). A frame whose Sa value differs from the previously received value in any enabled position sets status bit 0 (address 2) one clock after that frame is presented.
- R2: A difference that is only in positions whose enable bit is 0 leaves status bit 0 unchanged.
- R3: Output `sa_now`, and a read of address 3 (bits 4:0), show the Sa bits of the most recent frame, one clock after it is presented.
- R4: The codeword is the Sa6 bit of four consecutive non-align frames. The frame marked by `smf_sync` supplies bit 3, the most significant bit, and the last of the four supplies bit 0.
- R5: A completed codeword is stored in `sa6_code` (address 4, bits 3:0) only when it is equal to the two completed codewords just before it and differs from the stored value. Any different codeword restarts the run count at 1.
- R6: Storing a new codeword sets status bit 1, in the same clock that `sa6_code` changes.
- R7: `irq` is high exactly when (status bit 0 AND mask bit 0) OR (status bit 1 AND mask bit 1). The mask register is at address 1.
- R8: Writing 1 to a bit of the status register (address 2) clears that bit. When a clear and a new event for the same bit arrive in the same clock, the event wins.
- R9: After reset, the enable, mask and status registers, `sa_now` and `sa6_code` are all zero, and `irq` is low.
- R10: Frames that arrive before any `smf_sync` contribute no codeword bits. An `smf_sync` in the middle of a codeword throws away the bits collected so far and starts a new codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One-cycle strobe per received non-align frame |
| frame_sa | input | 5 | Sa bits of that frame, bit 0 = Sa4 .. bit 4 = Sa8 |
| smf_sync | input | 1 | With frame_vld: this frame starts a submultiframe |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| sa_now | output | 5 | Most recently received Sa bits |
| sa6_code | output | 4 | Accepted Sa6 codeword |
| irq | output | 1 | Interrupt request, level |

## Verification
Every registered result becomes visible one clock after the frame or write that causes it: `sa_now`, the change status, the stored codeword and its status bit all settle after the edge that samples the fourth Sa6 bit. `irq` and the read data then follow that same edge with no further delay. The bench drives its inputs on the falling edge. A behavioural model advances on the rising edge, and all outputs are compared one nanosecond after each falling edge, once the previous rising edge has settled everything. The directed checks read the registers only after the stimulus task has passed the sampling edge.

// File: rtl/sa_mon_pkg.sv
package sa_mon_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] A_SANOW  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CODE   = 3'd4;

    localparam int ST_CHG  = 0;
    localparam int ST_CODE = 1;
    localparam int ST_W    = 2;

    typedef enum logic {
        C_HUNT = 1'b0,
        C_FILL = 1'b1
    } coll_state_e;

    typedef enum logic [1:0] {
        F_EMPTY  = 2'd0,
        F_COUNT  = 2'd1,
        F_STABLE = 2'd2
    } filt_state_e;

endpackage

// File: rtl/sa_chg_detect.sv
module sa_chg_detect #(
    parameter int SA_N = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_vld,
    input  logic [SA_N-1:0] sa_in,
    input  logic [SA_N-1:0] watch_en,
    output logic [SA_N-1:0] sa_cur,
    output logic            chg
);

    logic [SA_N-1:0] diff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_cur <= '0;
        end else if (frm_vld) begin
            sa_cur <= sa_in;
        end
    end

    always_comb begin
        diff = (sa_in ^ sa_cur) & watch_en;
        chg  = frm_vld && (diff != '0);
    end

endmodule

// File: rtl/sa6_collect.sv
module sa6_collect
    import sa_mon_pkg::*;
#(
    parameter int CW_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_vld,
    input  logic            smf_sync,
    input  logic            sa6_bit,
    output logic            cw_done,
    output logic [CW_W-1:0] cw
);

    localparam int CNT_W = (CW_W > 2) ? $clog2(CW_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CW_W - 1);

    coll_state_e     st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CW_W-1:0] sh_q, sh_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= C_HUNT;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        sh_d  = sh_q;
        if (frm_vld) begin
            if (smf_sync) begin
                st_d  = C_FILL;
                cnt_d = CNT_W'(1);
                sh_d  = {{(CW_W-1){1'b0}}, sa6_bit};
            end else begin
                unique case (st_q)
                    C_HUNT: begin
                        st_d = C_HUNT;
                    end
                    C_FILL: begin
                        sh_d = {sh_q[CW_W-2:0], sa6_bit};
                        if (cnt_q == LAST) begin
                            st_d  = C_HUNT;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        cw      = {sh_q[CW_W-2:0], sa6_bit};
        cw_done = frm_vld && !smf_sync && (st_q == C_FILL) && (cnt_q == LAST);
    end

endmodule

// File: rtl/sa6_filter.sv
module sa6_filter
    import sa_mon_pkg::*;
#(
    parameter int CW_W     = 4,
    parameter int STABLE_N = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cw_done,
    input  logic [CW_W-1:0] cw,
    output logic [CW_W-1:0] code,
    output logic            upd
);

    localparam int RUN_W = $clog2(STABLE_N + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STABLE_N);

    filt_state_e     st_q, st_d;
    logic [RUN_W-1:0] run_q, run_nx;
    logic [CW_W-1:0] last_q;
    logic            same, stable_now;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= F_EMPTY;
            run_q  <= '0;
            last_q <= '0;
            code   <= '0;
        end else begin
            st_q <= st_d;
            if (cw_done) begin
                run_q  <= run_nx;
                last_q <= cw;
                if (upd) begin
                    code <= cw;
                end
            end
        end
    end

    // next state
    always_comb begin
        same       = (st_q != F_EMPTY) && (cw == last_q);
        run_nx     = !same ? RUN_W'(1)
                   : ((run_q >= RUN_MAX) ? RUN_MAX : run_q + RUN_W'(1));
        stable_now = (run_nx >= RUN_MAX);
        st_d       = st_q;
        if (cw_done) begin
            unique case (st_q)
                F_EMPTY:  st_d = stable_now ? F_STABLE : F_COUNT;
                F_COUNT:  st_d = stable_now ? F_STABLE : F_COUNT;
                F_STABLE: st_d = same ? F_STABLE : (stable_now ? F_STABLE : F_COUNT);
                default:  st_d = F_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        upd = cw_done && stable_now && (cw != code);
    end

endmodule

// File: rtl/sa_host_regs.sv
module sa_host_regs
    import sa_mon_pkg::*;
#(
    parameter int SA_N   = 5,
    parameter int CW_W   = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              ev_chg,
    input  logic              ev_code,
    input  logic [SA_N-1:0]   sa_cur,
    input  logic [CW_W-1:0]   code,
    output logic [SA_N-1:0]   en_q,
    output logic [ST_W-1:0]   mask_q,
    output logic [ST_W-1:0]   stat_q,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [ST_W-1:0] clr, set;
    wire unused_wdata = ^host_wdata[DATA_W-1:SA_N];

    always_comb begin
        clr          = (host_wr && host_addr == A_STATUS) ? host_wdata[ST_W-1:0] : '0;
        set          = '0;
        set[ST_CHG]  = ev_chg;
        set[ST_CODE] = ev_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (host_wr && host_addr == A_ENABLE) en_q   <= host_wdata[SA_N-1:0];
            if (host_wr && host_addr == A_MASK)   mask_q <= host_wdata[ST_W-1:0];
            stat_q <= (stat_q & ~clr) | set;
        end
    end

    always_comb begin
        rdata = '0;
        case (host_addr)
            A_ENABLE: rdata[SA_N-1:0] = en_q;
            A_MASK:   rdata[ST_W-1:0] = mask_q;
            A_STATUS: rdata[ST_W-1:0] = stat_q;
            A_SANOW:  rdata[SA_N-1:0] = sa_cur;
            A_CODE:   rdata[CW_W-1:0] = code;
            default:  rdata = '0;
        endcase
        irq = |(stat_q & mask_q);
    end

endmodule

// File: rtl/e1_sa_monitor.sv
module e1_sa_monitor
    import sa_mon_pkg::*;
#(
    parameter int SA_N     = 5,
    parameter int CW_W     = 4,
    parameter int STABLE_N = 3,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_vld,
    input  logic [SA_N-1:0]   frame_sa,
    input  logic              smf_sync,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [SA_N-1:0]   sa_now,
    output logic [CW_W-1:0]   sa6_code,
    output logic              irq
);

    localparam int SA6_IDX = 2;

    logic [SA_N-1:0] en_w;
    logic [ST_W-1:0] mask_w, stat_w;
    logic            chg_w, done_w, upd_w;
    logic [CW_W-1:0] cw_w;

    sa_chg_detect #(.SA_N(SA_N)) u_chg (
        .clk(clk), .rst_n(rst_n), .frm_vld(frame_vld), .sa_in(frame_sa),
        .watch_en(en_w), .sa_cur(sa_now), .chg(chg_w)
    );

    sa6_collect #(.CW_W(CW_W)) u_coll (
        .clk(clk), .rst_n(rst_n), .frm_vld(frame_vld), .smf_sync(smf_sync),
        .sa6_bit(frame_sa[SA6_IDX]), .cw_done(done_w), .cw(cw_w)
    );

    sa6_filter #(.CW_W(CW_W), .STABLE_N(STABLE_N)) u_filt (
        .clk(clk), .rst_n(rst_n), .cw_done(done_w), .cw(cw_w),
        .code(sa6_code), .upd(upd_w)
    );

    sa_host_regs #(.SA_N(SA_N), .CW_W(CW_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .ev_chg(chg_w), .ev_code(upd_w),
        .sa_cur(sa_now), .code(sa6_code), .en_q(en_w), .mask_q(mask_w),
        .stat_q(stat_w), .rdata(host_rdata), .irq(irq)
    );

endmodule

// File: rtl/e1_sa_monitor_chk.sv
module e1_sa_monitor_chk #(
    parameter int SA_N = 5,
    parameter int CW_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_vld,
    input logic [SA_N-1:0] frame_sa,
    input logic            host_wr,
    input logic [2:0]      host_addr,
    input logic [7:0]      host_wdata,
    input logic [SA_N-1:0] sa_now,
    input logic [CW_W-1:0] sa6_code,
    input logic            irq,
    input logic [SA_N-1:0] en_w,
    input logic [1:0]      mask_w,
    input logic [1:0]      stat_w
);

    // R1: the change status can only rise after a frame
    a_r1_chg_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_w[0]) |-> $past(frame_vld));

    // R2: no enabled difference, no new change status
    a_r2_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && (((frame_sa ^ sa_now) & en_w) == '0) && !stat_w[0]) |=> !stat_w[0]);

    // R3: live Sa value follows the last frame
    a_r3_now_tracks_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> (sa_now == $past(frame_sa)));

    // R5: stored codeword moves only after a frame
    a_r5_code_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sa6_code) |-> $past(frame_vld));

    // R6: a new stored codeword is flagged
    a_r6_code_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sa6_code) |-> stat_w[1]);

    // R7: fully masked status never interrupts
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == 2'b00) |-> !irq);

    // R8: write-one clears the code status when no frame competes
    a_r8_w1c_code: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd2 && host_wdata[1] && !frame_vld) |=> !stat_w[1]);

endmodule

bind e1_sa_monitor e1_sa_monitor_chk #(.SA_N(SA_N), .CW_W(CW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_sa(frame_sa),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .sa_now(sa_now), .sa6_code(sa6_code), .irq(irq),
    .en_w(en_w), .mask_w(mask_w), .stat_w(stat_w)
);

// File: tb/e1_sa_monitor_tb.sv
`timescale 1ns/1ps
module e1_sa_monitor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_vld = 1'b0;
    logic [4:0] frame_sa = '0;
    logic       smf_sync = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [4:0] sa_now;
    logic [3:0] sa6_code;
    logic       irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    e1_sa_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_sa(frame_sa),
        .smf_sync(smf_sync), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sa_now(sa_now),
        .sa6_code(sa6_code), .irq(irq)
    );

    // behavioural reference model
    logic [4:0] m_en, m_now;
    logic [1:0] m_mask, m_st;
    logic [3:0] m_code, m_prev;
    bit         m_have, m_coll;
    int         m_run;
    bit         m_q[$];

    always @(posedge clk) begin
        logic [1:0] set, clr;
        logic [3:0] cw;
        if (!rst_n) begin
            m_en = '0; m_now = '0; m_mask = '0; m_st = '0;
            m_code = '0; m_prev = '0; m_have = 0; m_coll = 0; m_run = 0;
            m_q.delete();
        end else begin
            set = '0;
            clr = '0;
            if (frame_vld) begin
                if (((frame_sa ^ m_now) & m_en) != 5'd0) set[0] = 1'b1;
                m_now = frame_sa;
                if (smf_sync) begin
                    m_q.delete();
                    m_q.push_back(frame_sa[2]);
                    m_coll = 1;
                end else if (m_coll) begin
                    m_q.push_back(frame_sa[2]);
                end
                if (m_coll && m_q.size() == 4) begin
                    cw = {m_q[0], m_q[1], m_q[2], m_q[3]};
                    m_coll = 0;
                    m_q.delete();
                    if (m_have && cw == m_prev) m_run = (m_run < 3) ? m_run + 1 : 3;
                    else m_run = 1;
                    m_have = 1;
                    m_prev = cw;
                    if (m_run >= 3 && cw != m_code) begin
                        m_code = cw;
                        set[1] = 1'b1;
                    end
                end
            end
            if (host_wr) begin
                case (host_addr)
                    3'd0: m_en = host_wdata[4:0];
                    3'd1: m_mask = host_wdata[1:0];
                    3'd2: clr = host_wdata[1:0];
                    default: ;
                endcase
            end
            m_st = (m_st & ~clr) | set;
        end
    end

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {3'b0, m_en};
            3'd1: return {6'b0, m_mask};
            3'd2: return {6'b0, m_st};
            3'd3: return {3'b0, m_now};
            3'd4: return {4'b0, m_code};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            chk("R3 sa_now", sa_now, m_now);
            chk("R5 sa6_code", sa6_code, m_code);
            chk("R7 irq", irq, |(m_st & m_mask));
            chk("R8 host_rdata", host_rdata, m_read(host_addr));
        end
    end

    task automatic idle();
        @(negedge clk);
        frame_vld = 0; smf_sync = 0; host_wr = 0;
    endtask

    task automatic frame(input logic [4:0] b, input bit sync);
        @(negedge clk);
        frame_vld = 1; frame_sa = b; smf_sync = sync; host_wr = 0;
        idle();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d; frame_vld = 0;
        idle();
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic send_cw(input logic [3:0] cw);
        for (int i = 0; i < 4; i++) frame({2'b00, cw[3-i], 2'b00}, i == 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R9 reset reg", d, 0);
        end
        chk("R9 reset irq", irq, 0);

        wr(3'd0, 8'h01);
        wr(3'd1, 8'h03);
        frame(5'b00010, 0);
        rd(3'd2, d); chk("R2 disabled Sa5 change", d, 0);
        frame(5'b00011, 0);
        rd(3'd2, d); chk("R1 enabled Sa4 change", d, 1);
        chk("R7 irq on unmasked change", irq, 1);
        rd(3'd3, d); chk("R3 current Sa read", d, 8'h03);
        wr(3'd1, 8'h00);
        chk("R7 masked no irq", irq, 0);
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h01);
        rd(3'd2, d); chk("R8 w1c clears", d, 0);

        wr(3'd0, 8'h00);
        frame(5'b00100, 0);
        frame(5'b00100, 0);
        send_cw(4'hA);
        send_cw(4'hA);
        rd(3'd4, d); chk("R5 two runs not enough", d, 0);
        send_cw(4'hA);
        rd(3'd4, d); chk("R4 codeword MSB first", d, 8'h0A);
        rd(3'd2, d); chk("R6 update status", d, 2);
        chk("R7 irq on code update", irq, 1);
        wr(3'd2, 8'h02);
        send_cw(4'hA);
        rd(3'd2, d); chk("R5 equal to stored no update", d, 0);
        send_cw(4'h5); send_cw(4'h5); send_cw(4'h3); send_cw(4'h5); send_cw(4'h5);
        rd(3'd4, d); chk("R5 run restarted", d, 8'h0A);
        send_cw(4'h5);
        rd(3'd4, d); chk("R5 third in a row", d, 8'h05);

        // R10 mid-codeword sync restarts
        frame(5'b00100, 1);
        frame(5'b00100, 0);
        send_cw(4'h6); send_cw(4'h6); send_cw(4'h6);
        rd(3'd4, d); chk("R10 restart on sync", d, 8'h06);

        // random traffic, compared by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            @(negedge clk);
            host_addr = 3'($urandom_range(0, 5));
            frame_vld = 0; smf_sync = 0; host_wr = 0;
            if (r < 60) begin
                frame_vld = 1;
                frame_sa = ($urandom_range(0, 3) == 0) ? 5'($urandom) : frame_sa;
                if ($urandom_range(0, 4) == 0) frame_sa[2] = ~frame_sa[2];
                smf_sync = ($urandom_range(0, 4) == 0);
            end else if (r < 72) begin
                host_wr = 1;
                host_wdata = 8'($urandom);
            end
        end
        idle();
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule